// File: doc/BRIEF.md
# Ring-Walking Memory-to-Memory DMA Channel

This channel moves blocks of bytes from one bus to another under the control of a ring of buffer descriptors held in a small descriptor RAM. Each descriptor gives a byte count, a source address, a destination address and a control word. The engine reads data from the source side into a staging buffer, then writes it out on the destination side. Read and write sizes are set separately, so large reads can feed a series of shorter writes. The first read and the first write of every descriptor also cover the gap up to the next 32-byte boundary, so that all later transfers start on that boundary. The staging buffer is modelled as an occupancy count only, and each bus is a request/acknowledge port that carries an address, a length, a bus select and a done flag.

Software uses one register port. It writes the descriptors into the RAM through a window at word addresses with bit 5 set, programs the ring base, the fill limit, the two transfer sizes, the destination-increment bit and the interrupt mask, and then issues start or stop commands. A control state machine walks the ring through six states. IDLE waits for start. FETCH reads the four descriptor words. CHECK goes to IDLE if the descriptor is invalid and to MOVE if it is valid. MOVE runs reads and writes. It goes to CLOSE when the byte count is used up, or to DRAIN when a stop is pending. DRAIN flushes the buffer to the destination and then goes to CLOSE. CLOSE writes back the control word, raises events and goes to FETCH, or to IDLE if the descriptor is the last one or a stop is pending.

Top module: `dma_ring_engine`

## Requirements
- R1: A start command in IDLE clears the staging count and loads the descriptor slot from ring base bits [6:4], so the low four bits of the base are ignored. A start while busy has no effect on the transfers in progress.
- R2: The first source read of a descriptor is (32 - src_addr mod 32) mod 32 + source size bytes. Each later read is the source size. Every read is cut down to the bytes still to be read.
- R3: If the destination address of a descriptor is not 32-aligned, its first write is the gap to the boundary plus the destination size minus 32. If it is aligned, the first write is the destination size. Each later write is the destination size. Every write is cut down to the bytes still to be written.
- R4: The source address advances by each acknowledged read length. The destination address advances by each acknowledged write length only when config bit 0 is 1, and stays fixed otherwise.
- R5: A read is issued only when the staging count plus its length is at most the fill limit plus 32. A write is issued in MOVE only when the staging count is at least its length.
- R6: Descriptor word 0 bits are: 0 valid, 1 wrap, 2 last, 3 interrupt, 4 source select, 5 destination select, 6 source done, 7 destination done. Word 1 is the count, word 2 the source address and word 3 the destination address. The select bits appear on src_sel and dst_sel. src_done and dst_done are set only on the final transfer of a side whose done bit is set.
- R7: CLOSE clears the valid bit in RAM. The slot then moves on by one descriptor (16 bytes), or returns to the ring base if the wrap bit is set.
- R8: A normal close sets event bit 0 when the interrupt or last bit is set. After a last descriptor the channel halts in IDLE and does not fetch further. Fetching an invalid descriptor halts the channel with no event.
- R9: A stop command stops new reads, writes everything still in the staging buffer, closes the descriptor, sets event bit 1 (not bit 0) and halts.
- R10: The event register (address 7) clears bits written with 1. irq is high exactly when an event bit and the matching mask bit (address 6) are both set.
- R11: After reset the channel is idle, with no bus requests, irq low and events clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register or descriptor-RAM write strobe |
| reg_addr | input | RAM_AW+1 (6) | Bit 5 set selects RAM word [4:0]; else register [2:0]: 0 cmd, 1 ring base, 2 config, 3 fill limit, 4 source size, 5 destination size, 6 mask, 7 events |
| reg_wdata | input | 32 | Write data; cmd bit 0 start, bit 1 stop |
| reg_rdata | output | 32 | Read data for reg_addr |
| src_req | output | 1 | Source read request, held until acknowledged |
| src_addr | output | ADDR_W (32) | Source read address |
| src_len | output | LEN_W (32) | Source read length in bytes |
| src_sel | output | 1 | Source bus select from the descriptor |
| src_done | output | 1 | Done marker on the final read |
| src_ack | input | 1 | Source read complete |
| dst_req | output | 1 | Destination write request, held until acknowledged |
| dst_addr | output | ADDR_W (32) | Destination write address |
| dst_len | output | LEN_W (32) | Destination write length in bytes |
| dst_sel | output | 1 | Destination bus select from the descriptor |
| dst_done | output | 1 | Done marker on the final write |
| dst_ack | input | 1 | Destination write complete |
| busy | output | 1 | Channel is not in IDLE |
| irq | output | 1 | Masked event interrupt |

## Verification
The main transfer path is driven with three descriptor shapes. The first has a source and destination 24 bytes off a 32-byte boundary and a count that is not a multiple of either size, which separates the misalignment absorption of the first read and first write from the tail truncation. The second is aligned, with destination increment off, which shows the fixed destination address and the plain first-write size. The third is a long descriptor cut short by a stop, where the bytes written must equal the bytes read and no read may start after the stop. Varying acknowledge delays on both sides shuffle how reads and writes interleave, while the per-side transfer sequences checked against the scoreboard must not change.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int BURST_BYTES = 32;

    // descriptor control word bit positions
    localparam int CB_VALID = 0;
    localparam int CB_WRAP  = 1;
    localparam int CB_LAST  = 2;
    localparam int CB_INT   = 3;
    localparam int CB_SSEL  = 4;
    localparam int CB_DSEL  = 5;
    localparam int CB_SDONE = 6;
    localparam int CB_DDONE = 7;

    // register indexes
    localparam logic [2:0] RG_CMD   = 3'd0;
    localparam logic [2:0] RG_RING  = 3'd1;
    localparam logic [2:0] RG_CFG   = 3'd2;
    localparam logic [2:0] RG_FILL  = 3'd3;
    localparam logic [2:0] RG_SSIZE = 3'd4;
    localparam logic [2:0] RG_DSIZE = 3'd5;
    localparam logic [2:0] RG_MASK  = 3'd6;
    localparam logic [2:0] RG_EVENT = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MOVE,
        ST_DRAIN,
        ST_CLOSE
    } dma_state_e;
endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
    parameter int WORDS = 32,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [31:0]   eng_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [31:0]   eng_wdata
);
    logic [31:0] mem [WORDS];

    // engine write-back is applied last, so it wins a same-word collision
    always_ff @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_wdata;
        if (eng_we)  mem[eng_waddr] <= eng_wdata;
    end

    assign host_rdata = mem[host_addr];
    assign eng_rdata  = mem[eng_raddr];
endmodule

// File: rtl/dma_xfer_size.sv
module dma_xfer_size #(
    parameter int LEN_W        = 32,
    parameter bit SHRINK_FIRST = 1'b0
) (
    input  logic [4:0]       addr_lo,
    input  logic             first,
    input  logic [LEN_W-1:0] size,
    input  logic [LEN_W-1:0] rem,
    output logic [LEN_W-1:0] len
);
    logic [5:0]       diff;
    logic [4:0]       gap;
    logic [LEN_W-1:0] first_len;
    logic [LEN_W-1:0] base;

    assign diff = 6'd32 - {1'b0, addr_lo};
    assign gap  = diff[4:0];

    generate
        if (SHRINK_FIRST) begin : g_shrink
            // destination: gap plus one burst fewer than the steady size
            assign first_len = (gap == 5'd0) ? size
                             : size + LEN_W'(gap) - LEN_W'(32);
        end else begin : g_grow
            // source: gap on top of the steady size
            assign first_len = size + LEN_W'(gap);
        end
    endgenerate

    assign base = first ? first_len : size;
    assign len  = (base < rem) ? base : rem;
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    input  logic             sub_en,
    input  logic [LEN_W-1:0] sub_len,
    input  logic [LEN_W:0]   cap,
    output logic [LEN_W-1:0] occ
);
    logic [LEN_W-1:0] occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      occ_q <= '0;
        else if (clr)    occ_q <= '0;
        else             occ_q <= occ_q + (add_en ? add_len : '0)
                                        - (sub_en ? sub_len : '0);
    end

    assign occ = occ_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, occ_q} <= cap);  // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> sub_len <= occ_q);  // R5
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
    import dma_pkg::*;
#(
    parameter int DESC_WORDS = 32,
    parameter int RAM_AW     = $clog2(DESC_WORDS),
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RAM_AW:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    output logic [LEN_W-1:0]  src_len,
    output logic              src_sel,
    output logic              src_done,
    input  logic              src_ack,
    output logic              dst_req,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [LEN_W-1:0]  dst_len,
    output logic              dst_sel,
    output logic              dst_done,
    input  logic              dst_ack,
    output logic              busy,
    output logic              irq
);
    localparam int SLOT_W = RAM_AW - 2;

    dma_state_e state, next_state;

    // configuration registers
    logic [SLOT_W-1:0] ring_slot;
    logic              dinc_q;
    logic [LEN_W-1:0]  fill_q, ssize_q, dsize_q;
    logic [1:0]        mask_q, evt_q;

    // engine state
    logic [SLOT_W-1:0] slot;
    logic [1:0]        fetch_idx;
    logic [31:0]       d_word0;
    logic [ADDR_W-1:0] src_a, dst_a;
    logic [LEN_W-1:0]  src_rem, dst_rem;
    logic              first_rd, first_wr, stop_pend;

    logic              reg_sel, start_cmd, stop_cmd;
    logic [1:0]        evt_clr, evt_set;
    logic [31:0]       host_rdata, eng_rdata;
    logic [LEN_W-1:0]  occ, rlen, wlen, wr_len;
    logic [LEN_W:0]    cap;
    logic              rd_go, wr_go;

    assign reg_sel   = reg_wr && !reg_addr[RAM_AW];
    assign start_cmd = reg_sel && reg_addr[2:0] == RG_CMD && reg_wdata[0];
    assign stop_cmd  = reg_sel && reg_addr[2:0] == RG_CMD && reg_wdata[1];
    assign evt_clr   = (reg_sel && reg_addr[2:0] == RG_EVENT) ? reg_wdata[1:0] : 2'b00;

    dma_desc_ram #(.WORDS(DESC_WORDS), .AW(RAM_AW)) i_ram (
        .clk        (clk),
        .host_we    (reg_wr && reg_addr[RAM_AW]),
        .host_addr  (reg_addr[RAM_AW-1:0]),
        .host_wdata (reg_wdata),
        .host_rdata (host_rdata),
        .eng_raddr  ({slot, fetch_idx}),
        .eng_rdata  (eng_rdata),
        .eng_we     (state == ST_CLOSE),
        .eng_waddr  ({slot, 2'b00}),
        .eng_wdata  (d_word0 & ~(32'd1 << CB_VALID))
    );

    dma_xfer_size #(.LEN_W(LEN_W), .SHRINK_FIRST(1'b0)) i_rd_size (
        .addr_lo (src_a[4:0]), .first (first_rd), .size (ssize_q),
        .rem (src_rem), .len (rlen)
    );

    dma_xfer_size #(.LEN_W(LEN_W), .SHRINK_FIRST(1'b1)) i_wr_size (
        .addr_lo (dst_a[4:0]), .first (first_wr), .size (dsize_q),
        .rem (dst_rem), .len (wlen)
    );

    assign cap = {1'b0, fill_q} + (LEN_W+1)'(BURST_BYTES);

    dma_stage_buf #(.LEN_W(LEN_W)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE && start_cmd),
        .add_en  (src_req && src_ack),
        .add_len (src_len),
        .sub_en  (dst_req && dst_ack),
        .sub_len (dst_len),
        .cap     (cap),
        .occ     (occ)
    );

    assign rd_go = state == ST_MOVE && !stop_pend && !stop_cmd && !src_req
                && src_rem != '0 && ({1'b0, occ} + {1'b0, rlen}) <= cap;
    assign wr_go = !dst_req && dst_rem != '0
                && ((state == ST_MOVE && occ >= wlen) || (state == ST_DRAIN && occ != '0));
    assign wr_len = (occ < wlen) ? occ : wlen;

    // register file and register read mux
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_slot <= '0;
            dinc_q    <= 1'b0;
            fill_q    <= '0;
            ssize_q   <= '0;
            dsize_q   <= '0;
            mask_q    <= '0;
        end else if (reg_sel) begin
            unique case (reg_addr[2:0])
                RG_RING:  ring_slot <= reg_wdata[RAM_AW+1:4];
                RG_CFG:   dinc_q    <= reg_wdata[0];
                RG_FILL:  fill_q    <= reg_wdata[LEN_W-1:0];
                RG_SSIZE: ssize_q   <= reg_wdata[LEN_W-1:0];
                RG_DSIZE: dsize_q   <= reg_wdata[LEN_W-1:0];
                RG_MASK:  mask_q    <= reg_wdata[1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[RAM_AW]) reg_rdata = host_rdata;
        else begin
            unique case (reg_addr[2:0])
                RG_RING:  reg_rdata = 32'({ring_slot, 4'b0000});
                RG_CFG:   reg_rdata = 32'(dinc_q);
                RG_FILL:  reg_rdata = 32'(fill_q);
                RG_SSIZE: reg_rdata = 32'(ssize_q);
                RG_DSIZE: reg_rdata = 32'(dsize_q);
                RG_MASK:  reg_rdata = 32'(mask_q);
                RG_EVENT: reg_rdata = 32'(evt_q);
                default:  reg_rdata = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // next state
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (start_cmd) next_state = ST_FETCH;
            ST_FETCH: if (fetch_idx == 2'd3) next_state = ST_CHECK;
            ST_CHECK: next_state = d_word0[CB_VALID] ? ST_MOVE : ST_IDLE;
            ST_MOVE: begin
                if (stop_pend)            next_state = ST_DRAIN;
                else if (dst_rem == '0)   next_state = ST_CLOSE;
            end
            ST_DRAIN: if (!src_req && !dst_req && occ == '0) next_state = ST_CLOSE;
            ST_CLOSE: next_state = (stop_pend || d_word0[CB_LAST]) ? ST_IDLE : ST_FETCH;
            default:  next_state = ST_IDLE;
        endcase
    end

    assign evt_set[0] = state == ST_CLOSE && !stop_pend
                     && (d_word0[CB_INT] || d_word0[CB_LAST]);
    assign evt_set[1] = state == ST_CLOSE && stop_pend;

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot      <= '0;
            fetch_idx <= '0;
            d_word0   <= '0;
            src_a     <= '0;
            dst_a     <= '0;
            src_rem   <= '0;
            dst_rem   <= '0;
            first_rd  <= 1'b0;
            first_wr  <= 1'b0;
            stop_pend <= 1'b0;
            evt_q     <= '0;
            src_req   <= 1'b0;
            src_len   <= '0;
            src_sel   <= 1'b0;
            src_done  <= 1'b0;
            dst_req   <= 1'b0;
            dst_len   <= '0;
            dst_sel   <= 1'b0;
            dst_done  <= 1'b0;
        end else begin
            evt_q <= (evt_q & ~evt_clr) | evt_set;

            if (state == ST_IDLE)  stop_pend <= 1'b0;
            else if (stop_cmd)     stop_pend <= 1'b1;

            if (state == ST_IDLE && start_cmd) begin
                slot      <= ring_slot;
                fetch_idx <= '0;
            end

            if (state == ST_FETCH) begin
                fetch_idx <= fetch_idx + 2'd1;
                unique case (fetch_idx)
                    2'd0: begin
                        d_word0  <= eng_rdata;
                        first_rd <= 1'b1;
                        first_wr <= 1'b1;
                    end
                    2'd1: begin
                        src_rem <= eng_rdata[LEN_W-1:0];
                        dst_rem <= eng_rdata[LEN_W-1:0];
                    end
                    2'd2: src_a <= eng_rdata[ADDR_W-1:0];
                    2'd3: dst_a <= eng_rdata[ADDR_W-1:0];
                    default: ;
                endcase
            end

            if (state == ST_CLOSE) begin
                slot      <= d_word0[CB_WRAP] ? ring_slot : slot + 1'b1;
                fetch_idx <= '0;
            end

            if (rd_go) begin
                src_req  <= 1'b1;
                src_len  <= rlen;
                src_sel  <= d_word0[CB_SSEL];
                src_done <= d_word0[CB_SDONE] && rlen == src_rem;
            end else if (src_req && src_ack) begin
                src_req  <= 1'b0;
                src_a    <= src_a + ADDR_W'(src_len);
                src_rem  <= src_rem - src_len;
                first_rd <= 1'b0;
            end

            if (wr_go) begin
                dst_req  <= 1'b1;
                dst_len  <= wr_len;
                dst_sel  <= d_word0[CB_DSEL];
                dst_done <= d_word0[CB_DDONE] && wr_len == dst_rem;
            end else if (dst_req && dst_ack) begin
                dst_req  <= 1'b0;
                if (dinc_q) dst_a <= dst_a + ADDR_W'(dst_len);
                dst_rem  <= dst_rem - dst_len;
                first_wr <= 1'b0;
            end
        end
    end

    assign src_addr = src_a;
    assign dst_addr = dst_a;
    assign busy     = state != ST_IDLE;
    assign irq      = |(evt_q & mask_q);

    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_ack) |=> (src_req && $stable(src_addr) && $stable(src_len)));  // R2
    AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req && !dst_ack) |=> (dst_req && $stable(dst_addr) && $stable(dst_len)));  // R3
    AST_SRC_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        src_req |-> src_len != '0);  // R2
    AST_DST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req && dst_ack && !dinc_q && state == ST_MOVE) |=> $stable(dst_addr));  // R4
    AST_NO_READ_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !src_req) |=> !src_req);  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> (!src_req && !dst_req));  // R11
endmodule

// File: tb/test_dma_ring_engine.sv
module test_dma_ring_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        src_req, src_sel, src_done, dst_req, dst_sel, dst_done;
    logic        src_ack = 1'b0, dst_ack = 1'b0;
    logic [31:0] src_addr, src_len, dst_addr, dst_len;
    logic        busy, irq;

    always #4 clk = ~clk;

    dma_ring_engine i_dma_ring_engine (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .src_req, .src_addr, .src_len, .src_sel, .src_done, .src_ack,
        .dst_req, .dst_addr, .dst_len, .dst_sel, .dst_done, .dst_ack,
        .busy, .irq
    );

    typedef struct packed {
        logic        sel;
        logic        dn;
        logic [31:0] addr;
        logic [31:0] len;
    } xfer_t;

    xfer_t       srcq[$];
    xfer_t       dstq[$];
    int          checks = 0, errors = 0;
    bit          strict = 1'b1, after_stop = 1'b0, finished = 1'b0;
    int          late_reads = 0, wr_acks = 0;
    longint      sum_rd = 0, sum_wr = 0;
    logic [31:0] next_wr_addr = '0;

    localparam int S_SIZE = 128, D_SIZE = 64, FILL = 128;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int s, input logic [31:0] ctrl, cnt, sa, da);
        wr(6'(32 + 4*s), ctrl);
        wr(6'(33 + 4*s), cnt);
        wr(6'(34 + 4*s), sa);
        wr(6'(35 + 4*s), da);
    endtask

    // driver side of the scoreboard: expected transfers from the requirements
    task automatic model(input logic [31:0] sa, da, cnt, input bit ss, ds, sdn, ddn, dinc);
        logic [31:0] a, rem, gap, base, len;
        bit first;
        a = sa; rem = cnt; first = 1'b1;
        while (rem != 0) begin
            gap  = (32 - (a % 32)) % 32;
            base = first ? gap + S_SIZE : S_SIZE;
            len  = (base < rem) ? base : rem;
            srcq.push_back({ss, sdn && len == rem, a, len});
            a += len; rem -= len; first = 1'b0;
        end
        a = da; rem = cnt; first = 1'b1;
        while (rem != 0) begin
            gap  = (32 - (a % 32)) % 32;
            base = !first ? D_SIZE : (gap == 0 ? D_SIZE : gap + D_SIZE - 32);
            len  = (base < rem) ? base : rem;
            dstq.push_back({ds, ddn && len == rem, a, len});
            if (dinc) a += len;
            rem -= len; first = 1'b0;
        end
    endtask

    // source monitor and responder
    initial begin
        xfer_t got, e;
        int dly;
        dly = 1;
        forever begin
            @(negedge clk);
            if (src_req) begin
                got = {src_sel, src_done, src_addr, src_len};
                if (after_stop) late_reads++;
                sum_rd += src_len;
                if (strict) begin
                    if (srcq.size() == 0) chk(1'b0, "R2", "unexpected read", got, '0);
                    else begin
                        e = srcq.pop_front();
                        chk(got == e, "R2 R4 R6", "read sel/done/addr/len", got, e);
                    end
                end
                repeat (dly) @(negedge clk);
                src_ack = 1'b1;
                @(negedge clk);
                src_ack = 1'b0;
                dly = (dly % 3) + 1;
            end
        end
    end

    // destination monitor and responder
    initial begin
        xfer_t got, e;
        int dly;
        dly = 0;
        forever begin
            @(negedge clk);
            if (dst_req) begin
                got = {dst_sel, dst_done, dst_addr, dst_len};
                sum_wr += dst_len;
                if (strict) begin
                    if (dstq.size() == 0) chk(1'b0, "R3", "unexpected write", got, '0);
                    else begin
                        e = dstq.pop_front();
                        chk(got == e, "R3 R4 R6", "write sel/done/addr/len", got, e);
                    end
                end else begin
                    chk(dst_addr == next_wr_addr, "R9", "drain write address",
                        66'(dst_addr), 66'(next_wr_addr));
                    next_wr_addr += dst_len;
                end
                repeat (dly) @(negedge clk);
                dst_ack = 1'b1;
                @(negedge clk);
                dst_ack = 1'b0;
                wr_acks++;
                dly = (dly + 1) % 3;
            end
        end
    end

    task automatic wait_idle();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy && n < 50000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !src_req && !dst_req, "R11", "idle after reset",
            66'({busy, src_req, dst_req}), 66'(0));
        chk(!irq, "R11", "irq after reset", 66'(irq), 66'(0));
        rst_n = 1'b1;
        rd(6'd7, v);
        chk(v == 0, "R11", "events after reset", 66'(v), 66'(0));

        for (int w = 0; w < 32; w++) wr(6'(32 + w), 32'd0);
        wr(6'd3, FILL);
        wr(6'd4, S_SIZE);
        wr(6'd5, D_SIZE);
        wr(6'd2, 32'd1);
        wr(6'd6, 32'd3);

        // test A: misaligned, tail truncation, done bits, wrap, restart ignored
        put_desc(2, 32'hD9, 32'd300, 32'h1008, 32'h8008);
        put_desc(3, 32'h23, 32'd64,  32'h2000, 32'h9000);
        put_desc(4, 32'h35, 32'd96,  32'h3000, 32'hA000);
        put_desc(5, 32'h01, 32'd32,  32'h3800, 32'hA800);
        model(32'h1008, 32'h8008, 32'd300, 1, 0, 1, 1, 1);
        model(32'h2000, 32'h9000, 32'd64,  0, 1, 0, 0, 1);
        wr(6'd1, 32'h25);                 // low bits set: ignored (R1)
        wr(6'd0, 32'd1);
        repeat (15) @(negedge clk);
        wr(6'd0, 32'd1);                  // R1: start while busy has no effect
        wait_idle();
        chk(!busy, "R8", "halt on invalid after wrap", 66'(busy), 66'(0));
        chk(srcq.size() == 0, "R1 R2", "reads outstanding", 66'(srcq.size()), 66'(0));
        chk(dstq.size() == 0, "R1 R3", "writes outstanding", 66'(dstq.size()), 66'(0));
        rd(6'(32 + 8), v);
        chk(v == 32'hD8, "R7", "slot 2 valid cleared", 66'(v), 66'(32'hD8));
        rd(6'(32 + 12), v);
        chk(v == 32'h22, "R7", "slot 3 valid cleared", 66'(v), 66'(32'h22));
        rd(6'(32 + 16), v);
        chk(v == 32'h35, "R7", "wrap skipped slot 4", 66'(v), 66'(32'h35));
        rd(6'd7, v);
        chk(v == 32'd1, "R8", "interrupt event", 66'(v), 66'(1));
        chk(irq, "R10", "irq with mask", 66'(irq), 66'(1));
        wr(6'd7, 32'd1);
        rd(6'd7, v);
        chk(v == 0, "R10", "event cleared by write one", 66'(v), 66'(0));
        chk(!irq, "R10", "irq after clear", 66'(irq), 66'(0));

        // test B: aligned, fixed destination, last bit, mask off
        wr(6'd2, 32'd0);
        wr(6'd6, 32'd0);
        model(32'h3000, 32'hA000, 32'd96, 1, 1, 0, 0, 0);
        wr(6'd1, 32'h40);
        wr(6'd0, 32'd1);
        wait_idle();
        chk(srcq.size() == 0 && dstq.size() == 0, "R4", "fixed destination sequence",
            66'(srcq.size() + dstq.size()), 66'(0));
        rd(6'(32 + 20), v);
        chk(v == 32'h01, "R8", "no fetch after last", 66'(v), 66'(1));
        rd(6'd7, v);
        chk(v == 32'd1, "R8", "last raises event", 66'(v), 66'(1));
        chk(!irq, "R10", "irq masked", 66'(irq), 66'(0));
        wr(6'd6, 32'd1);
        chk(irq, "R10", "irq after unmask", 66'(irq), 66'(1));
        wr(6'd7, 32'd3);

        // test C: stop mid-descriptor
        wr(6'd2, 32'd1);
        put_desc(5, 32'h01, 32'd4000, 32'h4010, 32'hB010);
        put_desc(6, 32'h05, 32'd32,   32'h5000, 32'hC000);
        strict = 1'b0; sum_rd = 0; sum_wr = 0; wr_acks = 0;
        next_wr_addr = 32'hB010;
        wr(6'd1, 32'h50);
        wr(6'd0, 32'd1);
        for (int n = 0; n < 2000 && wr_acks < 3; n++) @(negedge clk);
        wr(6'd0, 32'd2);
        #1 after_stop = 1'b1;
        wait_idle();
        after_stop = 1'b0;
        chk(late_reads == 0, "R9", "reads after stop", 66'(late_reads), 66'(0));
        chk(sum_wr == sum_rd, "R9", "buffer drained", 66'(sum_wr), 66'(sum_rd));
        chk(sum_rd < 4000, "R9", "stopped early", 66'(sum_rd), 66'(4000));
        rd(6'd7, v);
        chk(v == 32'd2, "R9", "stop event only", 66'(v), 66'(2));
        rd(6'(32 + 20), v);
        chk(v == 32'h00, "R9", "stopped descriptor closed", 66'(v), 66'(0));
        rd(6'(32 + 24), v);
        chk(v == 32'h05, "R9", "halt after stop", 66'(v), 66'(5));
        wr(6'd7, 32'd3);

        // test D: restart from the next slot with a cleared buffer
        strict = 1'b1;
        model(32'h5000, 32'hC000, 32'd32, 0, 0, 0, 0, 1);
        wr(6'd1, 32'h60);
        wr(6'd0, 32'd1);
        wait_idle();
        chk(srcq.size() == 0 && dstq.size() == 0, "R1", "restart sequence",
            66'(srcq.size() + dstq.size()), 66'(0));
        rd(6'd7, v);
        chk(v == 32'd1, "R8", "event after restart", 66'(v), 66'(1));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule